// File: doc/BRIEF.md
# Selectable Divided Clock Generator

The block takes one fast reference clock, nominally 240 MHz, and produces two divided clock outputs from it. Each output has its own 3-bit rate select. Output A can run at 80, 40, 20, 10, 5 or 2.5 MHz. Output B can run at 120, 60, 30, 15, 7.5 or 3.75 MHz. Every rate is an integer division of the same reference, so the two families keep a fixed 2:3 relation. All division uses counters in ordinary logic.

Each output is driven straight from a flip-flop clocked by the reference. A pulse shorter than one reference period therefore cannot reach the output. A new select value is captured on every reference edge, but it only takes effect when the current output period ends. Because all candidate rates share one source, a rate change needs no asynchronous handshake. Downstream logic is expected to use only the rising edges. Uneven duty cycle and arbitrary phase with respect to the reference are acceptable.

Top module: `clkdiv_gen`

## Requirements
- R1: Output A repeats every 3, 6, 12, 24, 48 or 96 reference cycles for select codes 0, 1, 2, 3, 4 and 5 respectively.
- R2: Output B repeats every 2, 4, 8, 16, 32 or 64 reference cycles for select codes 0, 1, 2, 3, 4 and 5 respectively.
- R3: Select codes 6 and 7 give the same period and high time as code 5 on either output.
- R4: With an even divisor, an output is high for exactly half of its period. With the divide-by-3 setting, output A is high for one reference cycle out of three.
- R5: While rstN is low at a reference rising edge, both outputs are low after that edge.
- R6: On the first reference edge at which rstN is high after a reset, both outputs rise. The first rising edge therefore appears well within one selected period.
- R7: A select change never shortens or stretches the period that is in progress. The new rate starts with the next period. Every high or low interval is exactly the high or low time of some valid setting, and never less than one reference cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Reference clock (240 MHz nominal); every register in the block runs on its rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| selA | input | 3 | Rate select for output A; codes 0..5 run from fastest to slowest, 6 and 7 act as 5 |
| selB | input | 3 | Rate select for output B; same encoding as selA |
| clkA | output | 1 | Divided clock A, registered on refClk |
| clkB | output | 1 | Divided clock B, registered on refClk |

## Verification
The hardest condition to reach from the ports is a rate change that arrives part-way through a long period. That is the point where a runt or a stretched interval would appear. The stimulus first waits for a rising edge on a channel that is running at its slowest rate. It then changes that channel's select to the fastest code about ten cycles later. It measures that the period in progress still completes at the old length and that the next period uses the new length. Throughout the whole run, a monitor compares every completed high and low interval against the set of interval lengths that valid settings allow. Resets applied in the middle of a period are also covered.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  // Per-channel edge commands from control to datapath
  typedef struct packed {
    logic rise;
    logic fall;
  } edgeStrobe_t;
endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
#(
  parameter int SEL_W     = 3,
  parameter int CNT_W     = 7,
  parameter int NUM_RATES = 6,
  parameter int BASE      = 3
) (
  input  logic             refClk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] sel,
  output edgeStrobe_t      strobe
);
  localparam logic [SEL_W-1:0] LAST_CODE = SEL_W'(NUM_RATES - 1);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  logic [SEL_W-1:0] selReg;
  logic [SEL_W-1:0] selClamped;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] activeDiv;
  logic [CNT_W-1:0] activeHi;
  logic [CNT_W-1:0] nextDiv;
  logic [CNT_W-1:0] nextHi;
  logic             reload;
  logic             endPeriod;

  // Out-of-range codes fall back to the slowest rate
  always_comb begin
    selClamped = (selReg > LAST_CODE) ? LAST_CODE : selReg;
    nextDiv    = CNT_W'(BASE) << selClamped;
    nextHi     = nextDiv[0] ? ONE : (nextDiv >> 1);
  end

  assign endPeriod   = (count == activeDiv - ONE);
  assign strobe.rise = reload | endPeriod;
  assign strobe.fall = !reload && (count == activeHi - ONE);

  always_ff @(posedge refClk) begin
    selReg <= sel;
    if (!rstN) begin
      count     <= '0;
      activeDiv <= CNT_W'(BASE);
      activeHi  <= ONE;
      reload    <= 1'b1;
    end else if (strobe.rise) begin
      // Period boundary: pick up the captured select
      count     <= '0;
      activeDiv <= nextDiv;
      activeHi  <= nextHi;
      reload    <= 1'b0;
    end else begin
      count <= count + ONE;
    end
  end
endmodule

// File: rtl/clkdiv_out.sv
module clkdiv_out
  import clkdiv_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                  refClk,
  input  logic                  rstN,
  input  edgeStrobe_t [NCH-1:0] strobeVec,
  output logic [NCH-1:0]        clkOut
);
  for (genvar g = 0; g < NCH; g++) begin : g_chan
    always_ff @(posedge refClk) begin
      if (!rstN)                 clkOut[g] <= 1'b0;
      else if (strobeVec[g].rise) clkOut[g] <= 1'b1;
      else if (strobeVec[g].fall) clkOut[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/clkdiv_gen.sv
module clkdiv_gen
  import clkdiv_pkg::*;
#(
  parameter int SEL_W     = 3,
  parameter int CNT_W     = 7,
  parameter int NUM_RATES = 6,
  parameter int BASE_A    = 3,
  parameter int BASE_B    = 2
) (
  input  logic             refClk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] selA,
  input  logic [SEL_W-1:0] selB,
  output logic             clkA,
  output logic             clkB
);
  localparam int NCH = 2;

  logic [NCH-1:0][SEL_W-1:0] selVec;
  edgeStrobe_t [NCH-1:0]     strobeVec;
  logic [NCH-1:0]            clkOut;

  assign selVec = {selB, selA};

  for (genvar g = 0; g < NCH; g++) begin : g_ctrl
    clkdiv_ctrl #(
      .SEL_W(SEL_W), .CNT_W(CNT_W), .NUM_RATES(NUM_RATES),
      .BASE((g == 0) ? BASE_A : BASE_B)
    ) u_ctrl (
      .refClk(refClk), .rstN(rstN), .sel(selVec[g]), .strobe(strobeVec[g])
    );
  end

  clkdiv_out #(.NCH(NCH)) u_out (
    .refClk(refClk), .rstN(rstN), .strobeVec(strobeVec), .clkOut(clkOut)
  );

  assign clkA = clkOut[0];
  assign clkB = clkOut[1];
endmodule

// File: rtl/clkdiv_gen_chk.sv
module clkdiv_gen_chk
  import clkdiv_pkg::*;
#(
  parameter int CNT_W     = 7,
  parameter int MAX_RUN_A = 48,
  parameter int MAX_RUN_B = 32
) (
  input logic                refClk,
  input logic                rstN,
  input logic                clkA,
  input logic                clkB,
  input edgeStrobe_t [1:0]   strobeVec
);
  logic             lastA, lastB;
  logic [CNT_W-1:0] runA, runB;

  always_ff @(posedge refClk) begin
    if (!rstN) begin
      lastA <= 1'b0; lastB <= 1'b0; runA <= '0; runB <= '0;
    end else begin
      lastA <= clkA; lastB <= clkB;
      runA  <= (clkA != lastA) ? CNT_W'(1) : runA + CNT_W'(1);
      runB  <= (clkB != lastB) ? CNT_W'(1) : runB + CNT_W'(1);
    end
  end

  p_reset_low_r5: assert property (@(posedge refClk)
    !rstN |=> (!clkA && !clkB));

  p_first_rise_r6: assert property (@(posedge refClk) disable iff (!rstN)
    ($past(rstN) == 1'b0) |=> (clkA && clkB));

  p_rise_a_r1: assert property (@(posedge refClk) disable iff (!rstN)
    strobeVec[0].rise |=> clkA);

  p_fall_b_r2: assert property (@(posedge refClk) disable iff (!rstN)
    strobeVec[1].fall |=> !clkB);

  p_one_cmd_r4: assert property (@(posedge refClk) disable iff (!rstN)
    $onehot0({strobeVec[0].rise, strobeVec[0].fall}) &&
    $onehot0({strobeVec[1].rise, strobeVec[1].fall}));

  p_run_a_r7: assert property (@(posedge refClk) disable iff (!rstN)
    (clkA != lastA) |-> (runA <= CNT_W'(MAX_RUN_A)));

  p_run_b_r7: assert property (@(posedge refClk) disable iff (!rstN)
    (clkB != lastB) |-> (runB <= CNT_W'(MAX_RUN_B)));
endmodule

bind clkdiv_gen clkdiv_gen_chk #(
  .CNT_W(CNT_W),
  .MAX_RUN_A((BASE_A << (NUM_RATES - 1)) / 2),
  .MAX_RUN_B((BASE_B << (NUM_RATES - 1)) / 2)
) u_chk (
  .refClk(refClk), .rstN(rstN), .clkA(clkA), .clkB(clkB), .strobeVec(strobeVec)
);

// File: tb/test_clkdiv_gen.sv
module test_clkdiv_gen;
  logic       refClk = 1'b0;
  logic       rstN   = 1'b0;
  logic [2:0] selA   = 3'd0;
  logic [2:0] selB   = 3'd0;
  logic       clkA, clkB;

  int  checks = 0, failures = 0;
  bit  done = 0;
  bit  monEn = 0;
  int  cyc = 0;
  int  riseCnt [2];
  int  lastRise [2];
  int  lastChange [2];
  int  lastPeriod [2];
  int  lastHigh [2];
  bit  armed [2];
  logic prevLvl [2];

  always #2 refClk = ~refClk;

  clkdiv_gen i_clkdiv_gen (
    .refClk(refClk), .rstN(rstN), .selA(selA), .selB(selB), .clkA(clkA), .clkB(clkB)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expDiv(int ch, int code);
    int c = (code > 5) ? 5 : code;
    return ((ch == 0) ? 3 : 2) << c;
  endfunction

  function automatic int expHigh(int d);
    return (d % 2 == 1) ? 1 : d / 2;
  endfunction

  function automatic bit runOk(int ch, bit hi, int len);
    for (int c = 0; c < 6; c++) begin
      int d = expDiv(ch, c);
      int h = expHigh(d);
      if (hi ? (len == h) : (len == d - h)) return 1;
    end
    return 0;
  endfunction

  // Monitor: outputs sampled at the falling edge, after they settle
  always @(negedge refClk) begin
    logic lvl [2];
    cyc++;
    lvl[0] = clkA;
    lvl[1] = clkB;
    for (int ch = 0; ch < 2; ch++) begin
      if (lvl[ch] !== prevLvl[ch]) begin
        if (armed[ch] && monEn)  // R7: interval must match a valid setting
          check(runOk(ch, prevLvl[ch], cyc - lastChange[ch]),
                (ch == 0) ? "R7 interval A" : "R7 interval B", cyc - lastChange[ch], -1);
        armed[ch] = monEn;
        lastChange[ch] = cyc;
        if (lvl[ch] === 1'b1) begin
          lastPeriod[ch] = cyc - lastRise[ch];
          lastRise[ch] = cyc;
          riseCnt[ch]++;
        end else begin
          lastHigh[ch] = cyc - lastRise[ch];
        end
      end
      prevLvl[ch] = lvl[ch];
    end
  end

  task automatic tick();
    @(negedge refClk);
    #1;
  endtask

  task automatic waitRises(int ch, int n);
    int s = riseCnt[ch];
    while (riseCnt[ch] < s + n) tick();
  endtask

  task automatic checkRates(int codeA, int codeB);
    int code [2];
    selA = 3'(codeA);
    selB = 3'(codeB);
    code[0] = codeA;
    code[1] = codeB;
    repeat (200) tick();
    for (int ch = 0; ch < 2; ch++) begin
      int d = expDiv(ch, code[ch]);
      waitRises(ch, 2);
      // R1/R2 period, R3 for codes 6/7, R4 high time
      check(lastPeriod[ch] == d,
            (ch == 0) ? ((codeA > 5) ? "R3 R1 period A" : "R1 period A")
                      : ((codeB > 5) ? "R3 R2 period B" : "R2 period B"),
            lastPeriod[ch], d);
      check(lastHigh[ch] == expHigh(d), "R4 high time", lastHigh[ch], expHigh(d));
    end
  endtask

  task automatic switchTest(int ch);
    if (ch == 0) selA = 3'd5; else selB = 3'd5;
    repeat (200) tick();
    waitRises(ch, 1);
    repeat (10) tick();
    if (ch == 0) selA = 3'd0; else selB = 3'd0;
    waitRises(ch, 1);
    check(lastPeriod[ch] == expDiv(ch, 5), "R7 period in progress kept", lastPeriod[ch], expDiv(ch, 5));
    waitRises(ch, 1);
    check(lastPeriod[ch] == expDiv(ch, 0), "R7 new rate next period", lastPeriod[ch], expDiv(ch, 0));
  endtask

  initial begin
    for (int ch = 0; ch < 2; ch++) begin
      riseCnt[ch] = 0; lastRise[ch] = 0; lastChange[ch] = 0;
      lastPeriod[ch] = 0; lastHigh[ch] = 0; armed[ch] = 0; prevLvl[ch] = 1'b0;
    end
    repeat (5) tick();
    check(clkA == 1'b0, "R5 reset A low", int'(clkA), 0);
    check(clkB == 1'b0, "R5 reset B low", int'(clkB), 0);
    selA = 3'd1; selB = 3'd2;
    tick();
    rstN = 1'b1;
    tick();
    check(clkA == 1'b1 && clkB == 1'b1, "R6 first rise after reset", int'({clkA, clkB}), 3);
    monEn = 1;

    // Sweep all codes on both channels
    for (int c = 0; c < 8; c++) checkRates(c, 7 - c);

    switchTest(0);
    switchTest(1);

    // Reset in the middle of slow periods
    selA = 3'd5; selB = 3'd5;
    repeat (150) tick();
    monEn = 0;
    rstN = 1'b0;
    tick();
    check(clkA == 1'b0 && clkB == 1'b0, "R5 mid-run reset low", int'({clkA, clkB}), 0);
    selA = 3'd2; selB = 3'd3;
    repeat (3) tick();
    check(clkA == 1'b0 && clkB == 1'b0, "R5 held reset low", int'({clkA, clkB}), 0);
    rstN = 1'b1;
    tick();
    check(clkA == 1'b1 && clkB == 1'b1, "R6 rise after mid-run reset", int'({clkA, clkB}), 3);
    monEn = 1;
    checkRates(2, 3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge refClk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule